// File: doc/BRIEF.md
# Time-Sliced Shared Memory Hub

The hub lets eight processor cores share one on-chip main memory. Access is granted by a fixed time-slot wheel. A free-running slot counter visits the cores in strict rotation, one per clock. A core is served only in its own slot, so each core gets exactly one window every eight cycles. If a core has nothing pending, its slot goes unused. No core can delay another, so the worst-case latency of every core is known in advance.

In its window, a core may move a byte, a 16-bit word, a 32-bit long, or four contiguous longs. The memory is one row of 128 bits wide. Each of these sizes therefore completes in a single slot. Byte-lane write strobes are derived from the low address bits. A request that is not aligned to its size has its low address bits forced to zero.

Each core holds its request until it sees its done pulse. The read data returns on a bus shared by all cores. The one-hot done vector marks which core owns that data.

Top module: `mem_hub`

## Requirements
- R1: The slot counter is 0 after reset and advances by one, modulo 8, on every clock. A request from core n is sampled only at an edge where the slot is n.
- R2: A request that is raised and held is served at the first edge whose slot equals its core index. Counting clock edges from the raise, done appears after ((n - slot) mod 8) + 1 edges, which is never more than 8.
- R3: A slot whose core has no request is left idle. No other core is served in it, and done_o stays all zero in the following cycle.
- R4: done_o is all zero during reset. After a served slot, only the bit of the served core is high, for one cycle only, for both reads and writes.
- R5: Size code 0 is a byte access.
  - A byte write stores wdata bits [7:0] at the address.
  - A byte read returns that byte in rdata_o[7:0], with the upper bits zero.
- R6: Size code 1 is a 16-bit word access with address bit 0 forced to 0.
  - The word is little-endian: the lower byte is at the lower address.
  - The data uses bits [15:0], and a read returns zeros above bit 15.
- R7: Size code 2 is a 32-bit long access with address bits [1:0] forced to 0.
  - The long is little-endian and uses bits [31:0].
  - On a write, be_i bit k enables byte k of the long.
  - A read returns zeros above bit 31.
- R8: Size code 3 is a quad access with address bits [3:0] forced to 0.
  - It moves 16 bytes and ignores be_i.
  - Byte i of the quad sits at data bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 8 | Request flag per core, held until done |
| we_i | input | 8 | Write enable per core |
| size_i | input | 16 | Access size per core, 2 bits each |
| addr_i | input | 136 | Byte address per core, 17 bits each |
| be_i | input | 32 | Byte enables per core for long writes, 4 bits each |
| wdata_i | input | 1024 | Write data per core, 128 bits each |
| done_o | output | 8 | One-cycle completion pulse per core |
| rdata_o | output | 128 | Read data for the core flagged in done_o |

## Verification
A core raised at a falling edge is due its done pulse after exactly ((n - slot) mod 8) + 1 rising edges. The read data is valid in that same cycle. The bench keeps its own copy of the slot wheel, reset with the design. It predicts the whole done vector at every falling edge and compares read data only in the cycle its done bit shows. Writes and reads update or consult a byte-wide reference memory, in the order the done pulses appear. That order is the order in which the memory saw them.

// File: rtl/hub_pkg.sv
`timescale 1ns/1ps
package hub_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_QUAD = 2'd3
  } size_e;

  localparam int unsigned ROW_BITS  = 128;
  localparam int unsigned ROW_LANES = ROW_BITS / 8;
  localparam int unsigned LANE_W    = $clog2(ROW_LANES);

  function automatic logic [LANE_W-1:0] align_mask(size_e sz);
    case (sz)
      SZ_BYTE: align_mask = 4'hF;
      SZ_WORD: align_mask = 4'hE;
      SZ_LONG: align_mask = 4'hC;
      default: align_mask = 4'h0;
    endcase
  endfunction
endpackage

// File: rtl/hub_slot.sv
`timescale 1ns/1ps
module hub_slot #(
  parameter int unsigned NUM_CORES = 8,
  localparam int unsigned SLOT_W = $clog2(NUM_CORES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [SLOT_W-1:0] slot_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_o <= '0;
    else if (slot_o == SLOT_W'(NUM_CORES - 1)) slot_o <= '0;
    else slot_o <= slot_o + 1'b1;
  end
endmodule

// File: rtl/hub_lane_map.sv
`timescale 1ns/1ps
module hub_lane_map import hub_pkg::*; #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned RIDX_W = 11
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  size_e                size_i,
  input  logic [3:0]           be_i,
  input  logic [ROW_BITS-1:0]  wdata_i,
  output logic [RIDX_W-1:0]    row_o,
  output logic [LANE_W-1:0]    off_o,
  output logic [ROW_LANES-1:0] lane_o,
  output logic [ROW_BITS-1:0]  wdata_o
);
  logic [ROW_LANES-1:0] base;

  always_comb begin
    case (size_i)
      SZ_BYTE: base = 16'h0001;
      SZ_WORD: base = 16'h0003;
      SZ_LONG: base = {12'h000, be_i};
      default: base = 16'hFFFF;
    endcase
  end

  assign row_o   = addr_i[RIDX_W+LANE_W-1:LANE_W];
  assign off_o   = addr_i[LANE_W-1:0] & align_mask(size_i);
  assign lane_o  = base << off_o;
  assign wdata_o = wdata_i << {off_o, 3'b000};
endmodule

// File: rtl/hub_ram.sv
`timescale 1ns/1ps
module hub_ram import hub_pkg::*; #(
  parameter int unsigned ROWS = 2048,
  localparam int unsigned RIDX_W = $clog2(ROWS)
) (
  input  logic                 clk_i,
  input  logic                 en_i,
  input  logic                 we_i,
  input  logic [RIDX_W-1:0]    row_i,
  input  logic [ROW_LANES-1:0] lane_i,
  input  logic [ROW_BITS-1:0]  wdata_i,
  output logic [ROW_BITS-1:0]  rdata_o
);
  logic [ROW_BITS-1:0] mem [ROWS];

  always_ff @(posedge clk_i) begin
    if (en_i && we_i) begin
      for (int l = 0; l < ROW_LANES; l++)
        if (lane_i[l]) mem[row_i][8*l +: 8] <= wdata_i[8*l +: 8];
    end
    if (en_i && !we_i) rdata_o <= mem[row_i];
  end
endmodule

// File: rtl/mem_hub.sv
`timescale 1ns/1ps
module mem_hub import hub_pkg::*; #(
  parameter int unsigned NUM_CORES = 8,
  parameter int unsigned ADDR_W    = 17,
  parameter int unsigned ROWS      = 2048,
  localparam int unsigned SLOT_W   = $clog2(NUM_CORES),
  localparam int unsigned RIDX_W   = $clog2(ROWS)
) (
  input  logic [0:0]                    clk_i,
  input  logic [0:0]                    rst_ni,
  input  logic [NUM_CORES-1:0]          req_i,
  input  logic [NUM_CORES-1:0]          we_i,
  input  logic [NUM_CORES*2-1:0]        size_i,
  input  logic [NUM_CORES*ADDR_W-1:0]   addr_i,
  input  logic [NUM_CORES*4-1:0]        be_i,
  input  logic [NUM_CORES*ROW_BITS-1:0] wdata_i,
  output logic [NUM_CORES-1:0]          done_o,
  output logic [ROW_BITS-1:0]           rdata_o
);
  logic [SLOT_W-1:0]    slot_q;
  logic                 access;
  logic                 sel_we;
  size_e                sel_size;
  logic [RIDX_W-1:0]    row;
  logic [LANE_W-1:0]    off;
  logic [ROW_LANES-1:0] lanes;
  logic [ROW_BITS-1:0]  wdata_sh;
  logic [ROW_BITS-1:0]  row_rd;
  logic [ROW_BITS-1:0]  rd_sh;
  logic [LANE_W-1:0]    off_q;
  size_e                size_q;

  hub_slot #(.NUM_CORES(NUM_CORES)) u_slot (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .slot_o(slot_q)
  );

  assign access   = req_i[slot_q];
  assign sel_we   = we_i[slot_q];
  assign sel_size = size_e'(size_i[slot_q*2 +: 2]);

  hub_lane_map #(.ADDR_W(ADDR_W), .RIDX_W(RIDX_W)) u_map (
    .addr_i (addr_i[slot_q*ADDR_W +: ADDR_W]),
    .size_i (sel_size),
    .be_i   (be_i[slot_q*4 +: 4]),
    .wdata_i(wdata_i[slot_q*ROW_BITS +: ROW_BITS]),
    .row_o  (row),
    .off_o  (off),
    .lane_o (lanes),
    .wdata_o(wdata_sh)
  );

  hub_ram #(.ROWS(ROWS)) u_ram (
    .clk_i  (clk_i),
    .en_i   (access),
    .we_i   (sel_we),
    .row_i  (row),
    .lane_i (lanes),
    .wdata_i(wdata_sh),
    .rdata_o(row_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= '0;
      off_q  <= '0;
      size_q <= SZ_BYTE;
    end else begin
      done_o <= access ? (NUM_CORES'(1) << slot_q) : '0;
      if (access) begin
        off_q  <= off;
        size_q <= sel_size;
      end
    end
  end

  // return path: shift the addressed bytes to bit 0, zero the rest
  assign rd_sh = row_rd >> {off_q, 3'b000};
  always_comb begin
    case (size_q)
      SZ_BYTE: rdata_o = {120'd0, rd_sh[7:0]};
      SZ_WORD: rdata_o = {112'd0, rd_sh[15:0]};
      SZ_LONG: rdata_o = {96'd0, rd_sh[31:0]};
      default: rdata_o = rd_sh;
    endcase
  end
endmodule

// File: rtl/hub_chk.sv
`timescale 1ns/1ps
module hub_chk #(
  parameter int unsigned NUM_CORES = 8,
  localparam int unsigned SLOT_W = $clog2(NUM_CORES)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [SLOT_W-1:0]    slot_i,
  input logic [NUM_CORES-1:0] req_i,
  input logic [NUM_CORES-1:0] done_i
);
  p_slot_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> slot_i == SLOT_W'($past(slot_i) + 1'b1));

  p_serve_in_slot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i[slot_i] |=> done_i == (NUM_CORES'(1) << $past(slot_i)));

  p_idle_slot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i[slot_i] |=> done_i == '0);

  p_done_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_i));

  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i != '0 |=> (done_i & $past(done_i)) == '0);
endmodule

bind mem_hub hub_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .slot_i(slot_q),
  .req_i (req_i),
  .done_i(done_o)
);

// File: tb/mem_hub_tb.sv
`timescale 1ns/1ps
module mem_hub_tb;
  localparam int NC = 8;
  localparam int AW = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NC-1:0]      req = '0, we = '0;
  logic [1:0]         sz   [NC];
  logic [AW-1:0]      ad   [NC];
  logic [3:0]         bes  [NC];
  logic [127:0]       wd   [NC];
  logic [NC*2-1:0]    size_f;
  logic [NC*AW-1:0]   addr_f;
  logic [NC*4-1:0]    be_f;
  logic [NC*128-1:0]  wdata_f;
  logic [NC-1:0]      done;
  logic [127:0]       rdata;

  always_comb
    for (int c = 0; c < NC; c++) begin
      size_f[c*2 +: 2]     = sz[c];
      addr_f[c*AW +: AW]   = ad[c];
      be_f[c*4 +: 4]       = bes[c];
      wdata_f[c*128 +: 128] = wd[c];
    end

  mem_hub u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(size_f),
    .addr_i(addr_f), .be_i(be_f), .wdata_i(wdata_f), .done_o(done), .rdata_o(rdata)
  );

  int checks = 0, fails = 0;
  logic [7:0] ref_mem [256];
  int tb_slot = 0, last_slot = 0;
  int raise_slot [NC];
  int edges [NC];

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin tb_slot <= 0; last_slot <= 0; end
    else begin last_slot <= tb_slot; tb_slot <= (tb_slot + 1) % NC; end

  function automatic int nbytes(logic [1:0] s);
    return (s == 2'd3) ? 16 : (1 << s);
  endfunction
  function automatic int base_of(logic [AW-1:0] a, logic [1:0] s);
    return int'(a) & ~(nbytes(s) - 1);
  endfunction
  function automatic logic [127:0] model_read(logic [AW-1:0] a, logic [1:0] s);
    logic [127:0] r = '0;
    for (int i = 0; i < nbytes(s); i++) r[8*i +: 8] = ref_mem[(base_of(a, s) + i) & 255];
    return r;
  endfunction

  task automatic model_write(logic [AW-1:0] a, logic [1:0] s, logic [3:0] b, logic [127:0] d);
    for (int i = 0; i < nbytes(s); i++)
      if (s != 2'd2 || b[i]) ref_mem[(base_of(a, s) + i) & 255] = d[8*i +: 8];
  endtask

  task automatic check(bit ok, string req_tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  function automatic string size_tag(logic [1:0] s);
    case (s) 2'd0: return "R5"; 2'd1: return "R6"; 2'd2: return "R7"; default: return "R8";
    endcase
  endfunction

  // run all cores flagged in pend; every field already set up
  task automatic run_round(logic [NC-1:0] pend_in);
    logic [NC-1:0] pend = pend_in;
    logic [NC-1:0] exp_done;
    for (int c = 0; c < NC; c++) if (pend[c]) begin raise_slot[c] = tb_slot; edges[c] = 0; end
    req = pend;
    while (pend != '0) begin
      @(posedge clk);
      @(negedge clk);
      for (int c = 0; c < NC; c++) if (pend[c]) edges[c]++;
      exp_done = pend[last_slot] ? (NC'(1) << last_slot) : '0;
      check(done == exp_done, "R1/R3 done vector", 128'(done), 128'(exp_done));
      for (int c = 0; c < NC; c++)
        if (pend[c] && done[c]) begin
          check(edges[c] == ((c - raise_slot[c] + NC) % NC) + 1, "R2 latency",
                128'(edges[c]), 128'(((c - raise_slot[c] + NC) % NC) + 1));
          if (we[c]) model_write(ad[c], sz[c], bes[c], wd[c]);
          else check(rdata == model_read(ad[c], sz[c]), size_tag(sz[c]), rdata,
                     model_read(ad[c], sz[c]));
          pend[c] = 1'b0;
          req[c]  = 1'b0;
        end
    end
    @(posedge clk);
    @(negedge clk);
    check(done == '0, "R4 pulse ends", 128'(done), 128'(0));
  endtask

  task automatic set_txn(int c, bit w, logic [1:0] s, logic [AW-1:0] a, logic [3:0] b,
                         logic [127:0] d);
    we[c] = w; sz[c] = s; ad[c] = a; bes[c] = b; wd[c] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int c = 0; c < NC; c++) set_txn(c, 0, 0, '0, 0, '0);
    repeat (3) @(negedge clk);
    check(done == '0, "R4 reset", 128'(done), 128'(0));
    rst_n = 1'b1;

    // fill the 256-byte test window with quad writes (R8)
    for (int q = 0; q < 16; q++) begin
      set_txn(q % NC, 1, 2'd3, AW'(q * 16 + 5), 4'h0,
              {$urandom, $urandom, $urandom, $urandom});
      run_round(NC'(1) << (q % NC));
    end

    // directed: R3 single core served only in its slot, worst-case wait R2
    wait (tb_slot == 4);
    set_txn(3, 0, 2'd2, AW'(8'h43), 4'hF, '0);
    run_round(8'b0000_1000);
    // R7 partial byte enables, misaligned long
    set_txn(6, 1, 2'd2, AW'(8'h27), 4'b0101, 128'hAABBCCDD);
    run_round(8'b0100_0000);
    set_txn(1, 0, 2'd2, AW'(8'h25), 4'h0, '0);
    run_round(8'b0000_0010);
    // R6 misaligned word, R5 byte
    set_txn(2, 1, 2'd1, AW'(8'h7F), 4'h0, 128'h1234);
    set_txn(5, 0, 2'd1, AW'(8'h7E), 4'h0, '0);
    set_txn(7, 0, 2'd0, AW'(8'h7F), 4'h0, '0);
    run_round(8'b1010_0100);

    // random mix (R1-R8)
    for (int n = 0; n < 600; n++) begin
      logic [NC-1:0] m;
      repeat ($urandom_range(0, 9)) @(negedge clk);
      m = NC'($urandom);
      for (int c = 0; c < NC; c++)
        set_txn(c, $urandom_range(0, 1), 2'($urandom), AW'($urandom & 255), 4'($urandom),
                {$urandom, $urandom, $urandom, $urandom});
      run_round(m);
    end

    // final quad sweep R8
    for (int q = 0; q < 16; q++) begin
      set_txn(q % NC, 0, 2'd3, AW'(q * 16), 4'h0, '0);
      run_round(NC'(1) << (q % NC));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule